// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit decides, for one 32-bit branch instruction, whether the branch is taken and where execution continues. It also produces the new values of the count and link registers. The surrounding core supplies the instruction word, the program counter, the 32-bit condition word, the count register and the link register, together with a valid strobe. One clock later the unit returns a taken flag, the next program counter and write enables with new values for both registers.

Four branch forms are handled. The first is an unconditional branch with a 24-bit word displacement. The second is a conditional branch with a 14-bit word displacement. The remaining two are conditional branches whose target comes from the count register or from the link register. A 5-bit option field sets the conditional behaviour through four separate controls: whether the counter is decremented, which counter test is used, whether the condition bit is ignored, and which condition polarity is wanted. A target-from-count branch that asks for the counter-zero test is reported as an illegal form. Such a branch is not taken and writes no register.

Top module: `branch_resolve`

## Requirements
- R1: While `rstN` is low, and after it is released until the first valid request has been registered, every output is zero.
- R2: Results appear on the clock edge after the one that samples `inValid` high, and `outValid` marks them. After a cycle with `inValid` low, all outputs are zero.
- R3: The form comes from instr[31:26]. Value 18 is the unconditional form and 16 is the conditional-displacement form. Value 19 selects the register-target forms through instr[10:1]: 528 takes the target from the count register and 16 takes it from the link register. Any other word is not a branch: `taken`=0, `nextPc`=pc+4, and neither register is written.
- R4: The displacement is instr[25:2] for the unconditional form and instr[15:2] for the conditional form. It is shifted left by two and sign-extended to 32 bits. When instr[1] is 0 the target is pc plus the displacement; when instr[1] is 1 the displacement itself is the target.
- R5: The option field is instr[25:21] and the bit selector is instr[20:16]. The condition bit is cr[31-selector]. The condition test passes when option bit value 16 is set, or when the condition bit equals option bit value 8.
- R6: For the conditional-displacement and link-target forms, a clear option bit value 4 writes the count register with ctr-1, whether or not the branch is taken. The counter test then passes when (ctr-1 != 0) XOR (option bit value 2) is true. A set option bit value 4 leaves the count register unwritten and passes the counter test.
- R7: A conditional branch is taken only when both the counter test and the condition test pass. A branch that is not taken gives `nextPc`=pc+4.
- R8: When instr[0] is 1 and the branch is taken, the link register is written with pc+4. The unconditional form is always taken. A branch that is not taken never writes the link register.
- R9: The count-target form uses the condition test only. It never writes the count register, and its target is ctr with the two low bits cleared.
- R10: The count-target form with option bit value 2 set raises `illegal`, is not taken (`nextPc`=pc+4) and writes neither register.
- R11: The link-target form uses the old link register with the two low bits cleared as its target, even when the same instruction writes the link register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; the inputs below are sampled when it is high |
| instr | input | 32 | Branch instruction word |
| pc | input | 32 | Address of the instruction |
| cr | input | 32 | Condition word |
| ctr | input | 32 | Current count register |
| lr | input | 32 | Current link register |
| outValid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| nextPc | output | 32 | Address of the next instruction |
| ctrWe | output | 1 | Count register write enable |
| ctrNew | output | 32 | New count register value |
| lrWe | output | 1 | Link register write enable |
| lrNew | output | 32 | New link register value |
| illegal | output | 1 | Illegal branch form |

## Verification
Directed words cover each form. Forward and backward displacements show that sign extension works, and relative versus absolute addressing shows that the pc is added only when it should be. Counts of 0, 1 and 5 under decrement, tried with both counter polarities, tell apart a test on the decremented count from a test on the old count, and also exercise the wrap-around. Condition bits set and clear under both polarities, and with the ignore control set, show that the bit index counts from the top of the word and that each control acts separately. Link targets with link update show that the old link value is used, and a long stream of random words of every form is compared on every clock against a behavioural model.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;

  localparam int OPC_W = 6;
  localparam int XO_W  = 10;
  localparam int BO_W  = 5;
  localparam int BI_W  = 5;
  localparam int CR_W  = 32;

  localparam logic [OPC_W-1:0] OPC_UNCOND = 6'd18;
  localparam logic [OPC_W-1:0] OPC_COND   = 6'd16;
  localparam logic [OPC_W-1:0] OPC_REGTGT = 6'd19;
  localparam logic [XO_W-1:0]  XO_VIA_LR  = 10'd16;
  localparam logic [XO_W-1:0]  XO_VIA_CTR = 10'd528;

  typedef enum logic [1:0] {
    SRC_DISP_LONG  = 2'd0,
    SRC_DISP_SHORT = 2'd1,
    SRC_CTR        = 2'd2,
    SRC_LR         = 2'd3
  } tgt_src_e;

  typedef struct packed {
    logic     taken;
    tgt_src_e tgtSrc;
    logic     absMode;
    logic     ctrDec;
    logic     lrLoad;
    logic     illegal;
  } strobes_t;

endpackage

// File: rtl/branch_resolve_ctrl.sv
module branch_resolve_ctrl
  import branch_resolve_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [BO_W-1:0]  bo,
  input  logic [BI_W-1:0]  bi,
  input  logic [XO_W-1:0]  xo,
  input  logic             aa,
  input  logic             lk,
  input  logic [CR_W-1:0]  crWord,
  input  logic             ctrDecNz,
  output strobes_t         strobes
);

  typedef enum logic [2:0] {
    FORM_NONE, FORM_UNCOND, FORM_COND, FORM_VIA_LR, FORM_VIA_CTR
  } form_e;

  form_e             form;
  logic [BI_W-1:0]   crIdx;
  logic              crBit;
  logic              crOk;
  logic              cntOk;

  always_comb begin
    form = FORM_NONE;
    if (opcode == OPC_UNCOND)      form = FORM_UNCOND;
    else if (opcode == OPC_COND)   form = FORM_COND;
    else if (opcode == OPC_REGTGT) begin
      if (xo == XO_VIA_LR)         form = FORM_VIA_LR;
      else if (xo == XO_VIA_CTR)   form = FORM_VIA_CTR;
    end
  end

  // Condition bit counted from the most significant end
  assign crIdx = BI_W'(CR_W - 1) - bi;
  assign crBit = crWord[crIdx];
  assign crOk  = bo[4] | (crBit == bo[3]);
  assign cntOk = bo[2] | (ctrDecNz ^ bo[1]);

  always_comb begin
    strobes = '0;
    unique case (form)
      FORM_UNCOND: begin
        strobes.taken   = 1'b1;
        strobes.tgtSrc  = SRC_DISP_LONG;
        strobes.absMode = aa;
        strobes.lrLoad  = lk;
      end
      FORM_COND: begin
        strobes.taken   = cntOk & crOk;
        strobes.tgtSrc  = SRC_DISP_SHORT;
        strobes.absMode = aa;
        strobes.ctrDec  = ~bo[2];
        strobes.lrLoad  = lk & cntOk & crOk;
      end
      FORM_VIA_LR: begin
        strobes.taken   = cntOk & crOk;
        strobes.tgtSrc  = SRC_LR;
        strobes.ctrDec  = ~bo[2];
        strobes.lrLoad  = lk & cntOk & crOk;
      end
      FORM_VIA_CTR: begin
        strobes.tgtSrc  = SRC_CTR;
        if (bo[1]) begin
          strobes.illegal = 1'b1;
        end else begin
          strobes.taken  = crOk;
          strobes.lrLoad = lk & crOk;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/branch_resolve_dp.sv
module branch_resolve_dp
  import branch_resolve_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  strobes_t        strobes,
  input  logic [23:0]     dispField,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] ctr,
  input  logic [XLEN-1:0] lr,
  output logic            ctrDecNz,
  output logic            outValid,
  output logic            taken,
  output logic [XLEN-1:0] nextPc,
  output logic            ctrWe,
  output logic [XLEN-1:0] ctrNew,
  output logic            lrWe,
  output logic [XLEN-1:0] lrNew,
  output logic            illegal
);

  localparam int LONG_W  = 26;
  localparam int SHORT_W = 16;
  localparam logic [XLEN-1:0] WORD_STEP = XLEN'(4);
  localparam logic [XLEN-1:0] LOW_CLR   = ~XLEN'(3);

  logic [XLEN-1:0] ctrDec;
  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] dispLong;
  logic [XLEN-1:0] dispShort;
  logic [XLEN-1:0] dispSel;
  logic [XLEN-1:0] immTarget;
  logic [XLEN-1:0] target;

  assign ctrDec   = ctr - XLEN'(1);
  assign ctrDecNz = |ctrDec;
  assign seqPc    = pc + WORD_STEP;

  assign dispLong  = {{(XLEN-LONG_W){dispField[23]}}, dispField, 2'b00};
  assign dispShort = {{(XLEN-SHORT_W){dispField[13]}}, dispField[13:0], 2'b00};
  assign dispSel   = (strobes.tgtSrc == SRC_DISP_LONG) ? dispLong : dispShort;
  assign immTarget = strobes.absMode ? dispSel : (pc + dispSel);

  always_comb begin
    unique case (strobes.tgtSrc)
      SRC_CTR: target = ctr & LOW_CLR;
      SRC_LR:  target = lr & LOW_CLR;
      default: target = immTarget;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !inValid) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
      nextPc   <= '0;
      ctrWe    <= 1'b0;
      ctrNew   <= '0;
      lrWe     <= 1'b0;
      lrNew    <= '0;
      illegal  <= 1'b0;
    end else begin
      outValid <= 1'b1;
      taken    <= strobes.taken;
      nextPc   <= strobes.taken ? target : seqPc;
      ctrWe    <= strobes.ctrDec;
      ctrNew   <= strobes.ctrDec ? ctrDec : '0;
      lrWe     <= strobes.lrLoad;
      lrNew    <= strobes.lrLoad ? seqPc : '0;
      illegal  <= strobes.illegal;
    end
  end

  // R7: a branch that is not taken falls through to the next word
  p_fallthrough_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !taken) |-> (nextPc == $past(pc) + WORD_STEP));

  // R6: the count write always carries the decremented count
  p_ctr_decrement_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrWe |-> (ctrNew == $past(ctr) - XLEN'(1)));

  // R8: link update only on a taken branch, with the return address
  p_link_value_r8: assert property (@(posedge clk) disable iff (!rstN)
    lrWe |-> (taken && lrNew == $past(pc) + WORD_STEP));

  // R10: an illegal form writes nothing and does not branch
  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (outValid && !taken && !ctrWe && !lrWe));

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import branch_resolve_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic [CR_W-1:0] cr,
  input  logic [XLEN-1:0] ctr,
  input  logic [XLEN-1:0] lr,
  output logic            outValid,
  output logic            taken,
  output logic [XLEN-1:0] nextPc,
  output logic            ctrWe,
  output logic [XLEN-1:0] ctrNew,
  output logic            lrWe,
  output logic [XLEN-1:0] lrNew,
  output logic            illegal
);

  strobes_t strobes;
  logic     ctrDecNz;

  branch_resolve_ctrl ctrl_i (
    .opcode   (instr[31:26]),
    .bo       (instr[25:21]),
    .bi       (instr[20:16]),
    .xo       (instr[10:1]),
    .aa       (instr[1]),
    .lk       (instr[0]),
    .crWord   (cr),
    .ctrDecNz (ctrDecNz),
    .strobes  (strobes)
  );

  branch_resolve_dp #(.XLEN(XLEN)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .strobes   (strobes),
    .dispField (instr[25:2]),
    .pc        (pc),
    .ctr       (ctr),
    .lr        (lr),
    .ctrDecNz  (ctrDecNz),
    .outValid  (outValid),
    .taken     (taken),
    .nextPc    (nextPc),
    .ctrWe     (ctrWe),
    .ctrNew    (ctrNew),
    .lrWe      (lrWe),
    .lrNew     (lrNew),
    .illegal   (illegal)
  );

  // R2: a sampled request always produces a marked result
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2: an idle cycle leaves every output quiet
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !taken && !ctrWe && !lrWe && !illegal));

endmodule

// File: tb/branch_resolve_tb_top.sv
module branch_resolve_tb_top;

  typedef struct {
    bit          valid;
    bit          taken;
    bit [31:0]   nextPc;
    bit          ctrWe;
    bit [31:0]   ctrNew;
    bit          lrWe;
    bit [31:0]   lrNew;
    bit          illegal;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0, pc = '0, cr = '0, ctr = '0, lr = '0;
  logic        outValid, taken, ctrWe, lrWe, illegal;
  logic [31:0] nextPc, ctrNew, lrNew;

  int checks = 0;
  int failures = 0;
  exp_t expQ[$];

  always #4 clk = ~clk;

  branch_resolve dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr), .pc(pc),
    .cr(cr), .ctr(ctr), .lr(lr), .outValid(outValid), .taken(taken),
    .nextPc(nextPc), .ctrWe(ctrWe), .ctrNew(ctrNew), .lrWe(lrWe),
    .lrNew(lrNew), .illegal(illegal)
  );

  function automatic bit [31:0] mkI(int li, bit aa, bit lk);
    bit [31:0] w = li;
    return {6'd18, w[23:0], aa, lk};
  endfunction
  function automatic bit [31:0] mkB(bit [4:0] bo, bit [4:0] bi, int bd, bit aa, bit lk);
    bit [31:0] w = bd;
    return {6'd16, bo, bi, w[13:0], aa, lk};
  endfunction
  function automatic bit [31:0] mkX(bit [4:0] bo, bit [4:0] bi, bit [9:0] xo, bit lk);
    return {6'd19, bo, bi, 5'd0, xo, lk};
  endfunction

  // Behavioural reference built from the requirements
  function automatic exp_t model(bit v, bit [31:0] w, bit [31:0] p, bit [31:0] c,
                                 bit [31:0] k, bit [31:0] l, string tag);
    exp_t e;
    int op, boV, biV, xoV;
    bit condPass, cntPass, go;
    bit [31:0] tgt, dec;
    e.valid = 0; e.taken = 0; e.nextPc = 0; e.ctrWe = 0; e.ctrNew = 0;
    e.lrWe = 0; e.lrNew = 0; e.illegal = 0; e.tag = tag;
    if (!v) return e;
    e.valid = 1;
    op = int'(w[31:26]); boV = int'(w[25:21]); biV = int'(w[20:16]); xoV = int'(w[10:1]);
    condPass = ((boV & 16) != 0) || (c[31 - biV] == ((boV & 8) != 0));
    dec = k - 1;
    cntPass = ((boV & 4) != 0) || ((dec != 0) != ((boV & 2) != 0));
    go = 0; tgt = 0;
    if (op == 18) begin
      tgt = {{6{w[25]}}, w[25:2], 2'b00};
      if (!w[1]) tgt = tgt + p;
      go = 1;
    end else if (op == 16) begin
      tgt = {{16{w[15]}}, w[15:2], 2'b00};
      if (!w[1]) tgt = tgt + p;
      if ((boV & 4) == 0) begin e.ctrWe = 1; e.ctrNew = dec; end
      go = cntPass && condPass;
    end else if (op == 19 && xoV == 16) begin
      tgt = {l[31:2], 2'b00};
      if ((boV & 4) == 0) begin e.ctrWe = 1; e.ctrNew = dec; end
      go = cntPass && condPass;
    end else if (op == 19 && xoV == 528) begin
      tgt = {k[31:2], 2'b00};
      if ((boV & 2) != 0) e.illegal = 1;
      else go = condPass;
    end
    e.taken = go;
    e.nextPc = go ? tgt : p + 4;
    if (go && w[0]) begin e.lrWe = 1; e.lrNew = p + 4; end
    return e;
  endfunction

  task automatic chk(string req, string what, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: compare the registered result, then drive
  task automatic step(bit v, bit [31:0] w, bit [31:0] p, bit [31:0] c,
                      bit [31:0] k, bit [31:0] l, string tag);
    exp_t e;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      chk({"R2 ", e.tag}, "outValid", 32'(outValid), 32'(e.valid));
      chk({"R7 ", e.tag}, "taken",    32'(taken),    32'(e.taken));
      chk({"R4 ", e.tag}, "nextPc",   nextPc,        e.nextPc);
      chk({"R6 ", e.tag}, "ctrWe",    32'(ctrWe),    32'(e.ctrWe));
      chk({"R6 ", e.tag}, "ctrNew",   ctrNew,        e.ctrNew);
      chk({"R8 ", e.tag}, "lrWe",     32'(lrWe),     32'(e.lrWe));
      chk({"R8 ", e.tag}, "lrNew",    lrNew,         e.lrNew);
      chk({"R10 ", e.tag}, "illegal", 32'(illegal),  32'(e.illegal));
    end
    inValid = v; instr = w; pc = p; cr = c; ctr = k; lr = l;
    expQ.push_back(model(v, w, p, cr, k, l, tag));
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", "outValid", 32'(outValid), 0);
    chk("R1", "taken", 32'(taken), 0);
    chk("R1", "nextPc", nextPc, 0);
    chk("R1", "writes", 32'({ctrWe, lrWe, illegal}), 0);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R1_idle_after_reset");
    // R3: a non-branch word falls through
    step(1, 32'h7C00_0000, 32'h1000, 32'hFFFF_FFFF, 5, 32'h40, "R3_not_branch");
    // R4: unconditional forward, backward, absolute with link
    step(1, mkI(32'h40, 0, 0), 32'h2000, 0, 0, 0, "R4_fwd");
    step(1, mkI(-8, 0, 0), 32'h2000, 0, 0, 0, "R4_back");
    step(1, mkI(32'h100, 1, 1), 32'h2000, 0, 0, 0, "R4_abs_R8_link");
    // R5: condition bit index counts from the top
    step(1, mkB(5'd12, 5'd2, 16, 0, 0), 32'h3000, 32'h2000_0000, 9, 0, "R5_bit_set");
    step(1, mkB(5'd12, 5'd2, 16, 0, 0), 32'h3000, 32'h0000_0004, 9, 0, "R5_bit_clear");
    step(1, mkB(5'd4, 5'd31, -4, 0, 1), 32'h3000, 32'hFFFF_FFFE, 9, 0, "R5_false_pol_R8");
    step(1, mkB(5'd20, 5'd0, -4, 1, 0), 32'h3000, 0, 9, 0, "R5_ignore_cond_abs");
    // R6: decrement and zero test on the decremented count
    step(1, mkB(5'd16, 5'd0, 8, 0, 0), 32'h4000, 0, 1, 0, "R6_dec_to_zero");
    step(1, mkB(5'd16, 5'd0, 8, 0, 0), 32'h4000, 0, 5, 0, "R6_dec_nonzero");
    step(1, mkB(5'd16, 5'd0, 8, 0, 0), 32'h4000, 0, 0, 0, "R6_dec_wrap");
    step(1, mkB(5'd18, 5'd0, 8, 0, 0), 32'h4000, 0, 1, 0, "R6_zero_pol");
    // R7: both tests must pass
    step(1, mkB(5'd0, 5'd0, 8, 0, 1), 32'h4000, 32'h8000_0000, 5, 0, "R7_cond_fails_R8_nolink");
    step(1, mkB(5'd0, 5'd0, 8, 0, 1), 32'h4000, 0, 5, 0, "R7_both_pass");
    step(0, mkB(5'd20, 5'd0, 8, 0, 1), 32'h4000, 0, 5, 0, "R2_idle");
    // R9: target from count register
    step(1, mkX(5'd20, 5'd0, 10'd528, 1), 32'h5000, 0, 32'h1237, 32'h99, "R9_ctr_target");
    step(1, mkX(5'd12, 5'd3, 10'd528, 0), 32'h5000, 0, 32'h1237, 0, "R9_ctr_cond_fail");
    // R10: illegal form
    step(1, mkX(5'd22, 5'd0, 10'd528, 1), 32'h5000, 0, 32'h1237, 0, "R10_illegal");
    // R11: target from link register, link updated at once
    step(1, mkX(5'd20, 5'd0, 10'd16, 1), 32'h6000, 0, 3, 32'h4003, "R11_lr_link");
    step(1, mkX(5'd16, 5'd0, 10'd16, 0), 32'h6000, 0, 3, 32'h8001, "R11_lr_dec");
    // Random mix of every form
    for (int i = 0; i < 600; i++) begin
      bit [31:0] w, p, c, k, l;
      int f;
      f = $urandom_range(0, 5);
      p = $urandom & 32'hFFFF_FFFC;
      c = $urandom; l = $urandom;
      k = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 2)) : $urandom;
      case (f)
        0: w = mkI(int'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
        1, 2: w = mkB(5'($urandom), 5'($urandom), int'($urandom), $urandom_range(0, 1) == 1,
                      $urandom_range(0, 1) == 1);
        3: w = mkX(5'($urandom), 5'($urandom), 10'd16, $urandom_range(0, 1) == 1);
        4: w = mkX(5'($urandom), 5'($urandom), 10'd528, $urandom_range(0, 1) == 1);
        default: w = $urandom;
      endcase
      step($urandom_range(0, 7) != 0, w, p, c, k, l, "R3_random");
    end
    step(0, 0, 0, 0, 0, 0, "R2_drain");
    step(0, 0, 0, 0, 0, 0, "R2_drain");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule